// File: doc/BRIEF.md
# Expansion Bank Mapper

This block controls a 64K bank of extra DRAM on an 8-bit CPU with a 16-bit address bus. The extra RAM is mapped over the top 32K of the address space. An 8-bit configuration register sets the mapping. Software writes the register at one fixed address and can never read it back. The block works out two things from the register and the current CPU cycle. The first is which 32K block of the extra RAM each upper-half access reaches, through an extra bank address bit. The second is whether the access goes to the extra RAM at all.

The upper 32K is split into a lower 16K half ($8000-$BFFF) and an upper 16K half ($C000-$FFFF). Each half has its own block select and its own write-protect bit. Two peek-through holes can be opened in the mapped window:
- the 4K video page at $8000-$8FFF;
- the I/O range at $E800-$EFFF.

Accesses in an open hole are refused, so the normal hardware answers them. The block also drives three more outputs:
- a column-enable strobe for the extra DRAM;
- a flag that tells the rest of the system the video page is no longer visible to the CPU;
- the enable for the buffer between the DRAM data lines and the CPU data bus.

Top module: `xbank_mapper`

## Requirements
- R1: After reset the register holds zero. The bank bit then equals A15, the column strobe is low and the screen-unmapped flag is low.
- R2: The register loads `wdata` at the rising clock edge only in a write cycle (`cpu_rw`=0) with `phi2` high at address $FFF0. The bit layout is:
  - bit 7: enable;
  - bit 6: I/O peek;
  - bit 5: screen peek;
  - bit 4: unused;
  - bit 3: block of the upper half;
  - bit 2: block of the lower half;
  - bit 1: write-protect of the upper half;
  - bit 0: write-protect of the lower half.

  A write to any other $FFxx address, a read of $FFF0 or a write with `phi2` low leaves the register unchanged.
- R3: While bit 7 is clear, `bank_a15` equals A15, `xcol_en` is low and `buf_en` equals `phi2` AND NOT `main_cas_n`.
- R4: While bit 7 is set, `bank_a15` is 0 below $8000. In $8000-$BFFF it equals bit 2 and in $C000-$FFFF it equals bit 3. It is forced to 1 inside an open peek hole.
- R5: `scr_unmapped` is high exactly when bit 7 is set and bit 5 is clear. It changes only after a register write.
- R6: With bit 7 set, a read at or above $8000 during `phi2` is accepted, except in $8000-$8FFF when bit 5 is set and in $E800-$EFFF when bit 6 is set.
- R7: A write is accepted under the same conditions as a read, and also only when the write-protect bit of its half is clear.
- R8: `xcol_en` is high exactly when the access is accepted and `main_cas_n` is high.
- R9: `buf_en` is high when an access is accepted, or when `phi2` is high and `main_cas_n` is low.
- R10: No access is accepted while `phi2` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| phi2 | input | 1 | CPU phase 2 (data phase) |
| wdata | input | 8 | CPU data bus for register writes |
| main_cas_n | input | 1 | Active-low select of the base RAM bank |
| bank_a15 | output | 1 | Address bit 15 for the extra RAM |
| xcol_en | output | 1 | Column enable for the extra RAM |
| scr_unmapped | output | 1 | Video page hidden from the CPU |
| buf_en | output | 1 | DRAM-to-CPU data buffer enable |

## Verification
The bench writes all 256 register values. After each write it sweeps reads and writes, both phase states and both base-RAM select states over addresses at every region edge. The addresses include $8FFF/$9000, $BFFF/$C000 and $E7FF/$E800/$EFFF/$F000.

Several kinds of fault show up in this sweep:
- A hole decoded one page off would refuse $E7FF or accept $E800.
- Crossed block or write-protect bits would map the wrong half.
- A missing phase qualifier would strobe the column line in phase 1.
- Swapped bits 5 and 6 would open the wrong hole.

Near-miss register writes to $FFF1, reads of $FFF0 and writes with phase 2 low catch an address decode that is too loose or an unqualified strobe.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
  parameter int AW = 16;
  parameter int DW = 8;

  // Register bit layout is software-visible, so field order is fixed.
  typedef struct packed {
    logic en;
    logic io_peek;
    logic scr_peek;
    logic spare;
    logic blk_hi;
    logic blk_lo;
    logic wp_hi;
    logic wp_lo;
  } xbm_cfg_t;

  // True when the address matches val on every bit set in care.
  function automatic logic f_hit(input logic [AW-1:0] a,
                                 input logic [AW-1:0] val,
                                 input logic [AW-1:0] care);
    return ((a ^ val) & care) == '0;
  endfunction
endpackage

// File: rtl/xbm_cfg_reg.sv
module xbm_cfg_reg
  import xbm_pkg::*;
#(
  parameter logic [AW-1:0] CFG_ADDR = 16'hFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rw,
  input  logic          phi2,
  input  logic [DW-1:0] wdata,
  output xbm_cfg_t      cfg_q,
  output logic          wr_fire
);
  localparam int PW = AW - 8;
  localparam logic [PW-1:0] PAGE = CFG_ADDR[AW-1:8];
  localparam logic [7:0]    OFS  = CFG_ADDR[7:0];

  logic page_wr;

  // First stage: any write into the register page.
  assign page_wr = phi2 & ~rw & (addr[AW-1:8] == PAGE);
  // Second stage: the one offset inside that page.
  assign wr_fire = page_wr & (addr[7:0] == OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (wr_fire) cfg_q <= xbm_cfg_t'(wdata);
  end
endmodule

// File: rtl/xbm_region.sv
module xbm_region
  import xbm_pkg::*;
(
  input  logic [AW-1:0] addr,
  output logic          upper,
  output logic          hi_half,
  output logic          scr_win,
  output logic          io_win
);
  localparam logic [AW-1:0] TOP  = 1 << (AW-1);
  localparam logic [AW-1:0] HALF = 1 << (AW-2);

  assign upper   = f_hit(addr, TOP, TOP);
  assign hi_half = f_hit(addr, TOP | HALF, TOP | HALF);
  assign scr_win = f_hit(addr, 16'h8000, 16'hF000);
  assign io_win  = f_hit(addr, 16'hE800, 16'hF800);
endmodule

// File: rtl/xbm_gate.sv
module xbm_gate
  import xbm_pkg::*;
(
  input  xbm_cfg_t cfg,
  input  logic     upper,
  input  logic     hi_half,
  input  logic     scr_win,
  input  logic     io_win,
  input  logic     rw,
  input  logic     phi2,
  input  logic     main_cas_n,
  output logic     bank_a15,
  output logic     accept,
  output logic     xcol_en,
  output logic     buf_en,
  output logic     scr_unmapped
);
  logic peek_scr, peek_io, peek_hit, blk_sel, wp_sel, unused_spare;

  assign unused_spare = cfg.spare;

  assign peek_scr = scr_win & cfg.scr_peek;
  assign peek_io  = io_win & cfg.io_peek;
  assign peek_hit = peek_scr | peek_io;
  assign blk_sel  = hi_half ? cfg.blk_hi : cfg.blk_lo;
  assign wp_sel   = hi_half ? cfg.wp_hi  : cfg.wp_lo;

  always_comb begin
    if (cfg.en) bank_a15 = (upper & blk_sel) | peek_hit;
    else        bank_a15 = upper;
  end

  assign accept       = phi2 & upper & cfg.en & ~peek_hit & (rw | ~wp_sel);
  assign xcol_en      = accept & main_cas_n;
  assign buf_en       = (phi2 & ~main_cas_n) | accept;
  assign scr_unmapped = cfg.en & ~cfg.scr_peek;
endmodule

// File: rtl/xbank_mapper.sv
module xbank_mapper
  import xbm_pkg::*;
#(
  parameter logic [AW-1:0] CFG_ADDR = 16'hFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rw,
  input  logic          phi2,
  input  logic [DW-1:0] wdata,
  input  logic          main_cas_n,
  output logic          bank_a15,
  output logic          xcol_en,
  output logic          scr_unmapped,
  output logic          buf_en
);
  xbm_cfg_t cfg_q;
  logic wr_fire, upper, hi_half, scr_win, io_win, accept;

  xbm_cfg_reg #(.CFG_ADDR(CFG_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .rw(cpu_rw), .phi2(phi2),
    .wdata(wdata), .cfg_q(cfg_q), .wr_fire(wr_fire)
  );

  xbm_region u_region (
    .addr(cpu_addr), .upper(upper), .hi_half(hi_half),
    .scr_win(scr_win), .io_win(io_win)
  );

  xbm_gate u_gate (
    .cfg(cfg_q), .upper(upper), .hi_half(hi_half), .scr_win(scr_win),
    .io_win(io_win), .rw(cpu_rw), .phi2(phi2), .main_cas_n(main_cas_n),
    .bank_a15(bank_a15), .accept(accept), .xcol_en(xcol_en),
    .buf_en(buf_en), .scr_unmapped(scr_unmapped)
  );
endmodule

// File: rtl/xbm_chk.sv
module xbm_chk
  import xbm_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_rw,
  input logic          phi2,
  input logic          main_cas_n,
  input logic          bank_a15,
  input logic          xcol_en,
  input logic          buf_en,
  input logic          scr_unmapped,
  input logic [DW-1:0] cfg_q,
  input logic          wr_fire,
  input logic          accept
);
  // R4
  low_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[AW-1] |-> !bank_a15);
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_fire) |-> $stable(cfg_q));
  // R5
  scr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scr_unmapped) |-> $past(wr_fire));
  // R8
  xcol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xcol_en |-> (phi2 && main_cas_n && cpu_addr[AW-1]));
  // R9
  buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xcol_en |-> buf_en);
  // R7
  wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_rw) |-> !(cpu_addr[AW-2] ? cfg_q[1] : cfg_q[0]));
  // R6
  peek_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !(cpu_addr[AW-1:AW-4] == 4'h8 && cfg_q[5]));
  // R3
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[7] |-> (bank_a15 == cpu_addr[AW-1] && !xcol_en));
endmodule

bind xbank_mapper xbm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
  .phi2(phi2), .main_cas_n(main_cas_n), .bank_a15(bank_a15),
  .xcol_en(xcol_en), .buf_en(buf_en), .scr_unmapped(scr_unmapped),
  .cfg_q(cfg_q), .wr_fire(wr_fire), .accept(accept)
);

// File: tb/xbank_mapper_bench.sv
module xbank_mapper_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic cpu_rw = 1'b1;
  logic phi2 = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic main_cas_n = 1'b1;
  logic bank_a15, xcol_en, scr_unmapped, buf_en;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  xbank_mapper u_xbank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
    .phi2(phi2), .wdata(wdata), .main_cas_n(main_cas_n),
    .bank_a15(bank_a15), .xcol_en(xcol_en),
    .scr_unmapped(scr_unmapped), .buf_en(buf_en)
  );

  localparam logic [15:0] ADDRS [16] = '{
    16'h0000, 16'h7FFF, 16'h8000, 16'h8FFF, 16'h9000, 16'hA5A5,
    16'hBFFF, 16'hC000, 16'hD123, 16'hE7FF, 16'hE800, 16'hEC00,
    16'hEFFF, 16'hF000, 16'hFFF1, 16'hFFFF};

  // Expected {bank, xcol, scr, buf}, derived from the requirements.
  function automatic logic [3:0] model(input logic [7:0] c, input int a,
                                       input logic rd, input logic ph,
                                       input logic mn);
    logic bank, acc, speek, ipeek, prot;
    speek = c[5] && a >= 'h8000 && a < 'h9000;
    ipeek = c[6] && a >= 'hE800 && a < 'hF000;
    if (!c[7]) begin
      bank = (a >= 'h8000);
      acc  = 1'b0;
    end else begin
      if (a >= 'hC000)      bank = c[3];
      else if (a >= 'h8000) bank = c[2];
      else                  bank = 1'b0;
      bank = bank | speek | ipeek;
      prot = (a >= 'hC000) ? c[1] : c[0];
      acc  = ph && a >= 'h8000 && !speek && !ipeek && (rd || !prot);
    end
    return {bank, acc && mn, c[7] && !c[5], (ph && !mn) || acc};
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b (addr=%h rw=%b phi2=%b mcas_n=%b)",
               req, got, exp, cpu_addr, cpu_rw, phi2, main_cas_n);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                           input logic rd, input logic ph);
    @(negedge clk);
    cpu_addr = a; wdata = d; cpu_rw = rd; phi2 = ph;
    @(posedge clk);
    #1;
    cpu_addr = 16'h0000; cpu_rw = 1'b1; phi2 = 1'b0;
    #1;
  endtask

  task automatic probe(input logic [7:0] c, input logic [15:0] a,
                       input logic rd, input logic ph, input logic mn);
    logic [3:0] e;
    cpu_addr = a; cpu_rw = rd; phi2 = ph; main_cas_n = mn;
    #1;
    e = model(c, int'(a), rd, ph, mn);
    check(c[7] ? "R4 bank" : "R3 bank", bank_a15, e[3]);
    check(!ph ? "R10 xcol" : (rd ? "R6 R8 xcol" : "R7 R8 xcol"), xcol_en, e[2]);
    check("R5 scr", scr_unmapped, e[1]);
    check(!ph ? "R10 buf" : "R9 buf", buf_en, e[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R1: reset state
    foreach (ADDRS[i]) probe(8'h00, ADDRS[i], 1'b1, 1'b1, 1'b1);
    check("R1 scr", scr_unmapped, 1'b0);

    // R2: near-miss writes must leave the register alone
    bus_write(16'hFFF0, 8'h80, 1'b0, 1'b1);
    check("R2 load", scr_unmapped, 1'b1);
    bus_write(16'hFFF1, 8'hA0, 1'b0, 1'b1);
    check("R2 other page offset", scr_unmapped, 1'b1);
    bus_write(16'hFFF0, 8'hA0, 1'b1, 1'b1);
    check("R2 read cycle", scr_unmapped, 1'b1);
    bus_write(16'hFFF0, 8'hA0, 1'b0, 1'b0);
    check("R2 phi2 low", scr_unmapped, 1'b1);
    bus_write(16'h7FF0, 8'hA0, 1'b0, 1'b1);
    check("R2 other page", scr_unmapped, 1'b1);
    bus_write(16'hFFF0, 8'hA0, 1'b0, 1'b1);
    check("R2 reload", scr_unmapped, 1'b0);

    // Full sweep of register values against all region edges
    for (int c = 0; c < 256; c++) begin
      bus_write(16'hFFF0, 8'(c), 1'b0, 1'b1);
      foreach (ADDRS[i])
        for (int k = 0; k < 8; k++)
          probe(8'(c), ADDRS[i], k[0], k[1], k[2]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule